// File: doc/BRIEF.md
# Two-Port Memory with Same-Location Arbitration

A synchronous memory of 2048 words of 8 bits. It has two fully independent access ports, called left and right. Each port has an active-low select, an active-low write strobe, an active-low output enable, an 11-bit word address and 8-bit write and read data. Accesses to different words go ahead on both ports in the same cycle. When both ports are selected on the same word, an arbiter lets one port through. It pulls the active-low busy output of the other port low until the conflict ends.

The arbiter chooses by order of arrival, judged in whole clock cycles. If the two addresses were already equal when the selects went low, the port selected in an earlier cycle wins. If both ports were already selected when their addresses came to match, the port whose address was present first wins. A tie in either case goes to the left port. The grant stays with the winner for as long as the conflict lasts. A conflict ends when the winner deselects or moves its address. The blocked port then runs in that same cycle. If its write strobe is still low, its held write is performed.

Writes take effect at the clock edge. Reads are registered: the word read in one cycle is presented in the next cycle, and only while that port's output enable is low. When not presented, the read bus shows zero and its drive flag is low. The reset input is asynchronous and active low. It is released internally through a two-stage synchronizer.

Top module: `dpram_arb`

## Requirements
- R1: A word written through either port at any address from 0 to 2047 is returned by a later read of that address from either port. A read made in cycle n appears on the port's read bus in cycle n+1.
- R2: A port whose select is high performs no read or write, and its busy output stays high, whatever the other port is doing.
- R3: When both ports are selected on different addresses, both writes or both reads complete in the same cycle without interfering.
- R4: A port's drive flag is high only while its output enable is low and it made an unblocked read in the previous cycle. Otherwise the flag is low and the read bus shows zero.
- R5: Busy is low only on a port that is selected on the same address as the other selected port. At most one busy output is low at any time, and the two ports never write the same word in one cycle.
- R6: If the addresses already match when a conflict starts, the port selected in an earlier cycle wins. If both selects fall in the same cycle, the left port wins.
- R7: If both ports were selected in the previous cycle and only one address changed to create the match, the port whose address did not change wins. If both addresses changed in the same cycle, the left port wins.
- R8: While its busy is low, a port's write leaves memory unchanged and its read produces no data (drive flag low in the next cycle).
- R9: Busy on the blocked port returns high in the cycle the winner deselects or changes address. A write still held by the blocked port is performed at the end of that cycle.
- R10: Once granted, the winner keeps the grant for every cycle that the conflict continues.
- R11: After reset is released, both busy outputs are high and both drive flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_q | output | 8 | Left read data, zero when not driven |
| l_q_en | output | 1 | Left read bus drive flag |
| l_busy_n | output | 1 | Left busy, low while left is blocked |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_q | output | 8 | Right read data, zero when not driven |
| r_q_en | output | 1 | Right read bus drive flag |
| r_busy_n | output | 1 | Right busy, low while right is blocked |

## Verification
A stale or wrong grant register shows at once as the wrong busy output going low in the first conflicting cycle. It also shows as a busy output that flips partway through a conflict that still holds. A corrupted history of selects or addresses shows only at the start of a conflict, as the wrong winner under one of the two arrival orders, so each order and each tie is driven on its own. A missing write block or a dropped pending write shows only later, when the location is read back two cycles after the conflict ends.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
  typedef enum logic [1:0] {
    GR_NONE  = 2'd0,
    GR_LEFT  = 2'd1,
    GR_RIGHT = 2'd2
  } grant_e;
endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dpram_collide.sv
// Detects same-word access and keeps one cycle of history on both ports,
// so the arbiter can tell which event arrived first.
module dpram_collide #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              conflict,
  output logic              prev_l_sel,
  output logic              prev_r_sel,
  output logic              l_moved,
  output logic              r_moved
);
  logic [ADDR_W-1:0] prev_l_addr_q, prev_r_addr_q;
  logic              prev_l_sel_q,  prev_r_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l_sel_q  <= 1'b0;
      prev_r_sel_q  <= 1'b0;
      prev_l_addr_q <= '0;
      prev_r_addr_q <= '0;
    end else begin
      prev_l_sel_q  <= l_sel;
      prev_r_sel_q  <= r_sel;
      prev_l_addr_q <= l_addr;
      prev_r_addr_q <= r_addr;
    end
  end

  always_comb begin
    conflict   = l_sel && r_sel && (l_addr == r_addr);
    l_moved    = (l_addr != prev_l_addr_q);
    r_moved    = (r_addr != prev_r_addr_q);
    prev_l_sel = prev_l_sel_q;
    prev_r_sel = prev_r_sel_q;
  end
endmodule

// File: rtl/dpram_arbiter.sv
// Picks the winner of a new conflict by arrival order and holds the grant
// until the conflict ends.
module dpram_arbiter
  import dpram_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conflict,
  input  logic prev_l_sel,
  input  logic prev_r_sel,
  input  logic l_moved,
  input  logic r_moved,
  output logic l_block,
  output logic r_block
);
  grant_e grant_q, grant_d, fresh, winner;

  always_comb begin
    if (prev_l_sel && prev_r_sel) begin
      // both were selected: the address present first takes the word
      fresh = (l_moved && !r_moved) ? GR_RIGHT : GR_LEFT;
    end else begin
      // selects decide: the earlier select takes the word
      fresh = (prev_r_sel && !prev_l_sel) ? GR_RIGHT : GR_LEFT;
    end
    winner  = (grant_q != GR_NONE) ? grant_q : fresh;
    grant_d = conflict ? winner : GR_NONE;
    l_block = conflict && (winner == GR_RIGHT);
    r_block = conflict && (winner == GR_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= GR_NONE;
    else        grant_q <= grant_d;
  end

  AST_ONE_SIDE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_block && r_block)); // R5
  AST_IDLE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |-> (!l_block && !r_block)); // R5
  AST_LEFT_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q == GR_LEFT && conflict) |-> (r_block && !l_block)); // R10
  AST_RIGHT_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q == GR_RIGHT && conflict) |-> (l_block && !r_block)); // R10
endmodule

// File: rtl/dpram_port.sv
// One access port: gates the access by select and block, and registers read data.
module dpram_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              blocked,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sel,
  output logic              wr_en,
  output logic              rd_en,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  logic              rd_q, rd_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              access;

  always_comb begin
    sel     = !cs_n;
    access  = sel && !blocked;
    wr_en   = access && !we_n;
    rd_en   = access && we_n;
    rd_d    = rd_en;
    rdata_d = rd_en ? mem_rdata : rdata_q;
    q_en    = rd_q && !oe_n;
    q       = q_en ? rdata_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rd_q    <= rd_d;
      rdata_q <= rdata_d;
    end
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!wr_en && !rd_en)); // R2
  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !wr_en); // R8
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |-> !oe_n); // R4
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |-> $past(rd_en)); // R1
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  assign l_rdata = mem[l_addr];
  assign r_rdata = mem[r_addr];

  AST_WRITES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && r_wr) |-> (l_addr != r_addr)); // R5
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_q,
  output logic              l_q_en,
  output logic              l_busy_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_q,
  output logic              r_q_en,
  output logic              r_busy_n
);
  logic              srst_n;
  logic              l_sel, r_sel, l_wr, r_wr, l_rd, r_rd;
  logic              conflict, prev_l_sel, prev_r_sel, l_moved, r_moved;
  logic              l_block, r_block;
  logic [DATA_W-1:0] l_mem_rd, r_mem_rd;

  dpram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n)
  );

  dpram_collide #(.ADDR_W(ADDR_W)) u_collide (
    .clk(clk), .rst_n(srst_n),
    .l_sel(l_sel), .r_sel(r_sel), .l_addr(l_addr), .r_addr(r_addr),
    .conflict(conflict), .prev_l_sel(prev_l_sel), .prev_r_sel(prev_r_sel),
    .l_moved(l_moved), .r_moved(r_moved)
  );

  dpram_arbiter u_arb (
    .clk(clk), .rst_n(srst_n), .conflict(conflict),
    .prev_l_sel(prev_l_sel), .prev_r_sel(prev_r_sel),
    .l_moved(l_moved), .r_moved(r_moved),
    .l_block(l_block), .r_block(r_block)
  );

  dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
    .clk(clk), .rst_n(srst_n), .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .blocked(l_block), .mem_rdata(l_mem_rd),
    .sel(l_sel), .wr_en(l_wr), .rd_en(l_rd), .q(l_q), .q_en(l_q_en)
  );

  dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
    .clk(clk), .rst_n(srst_n), .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .blocked(r_block), .mem_rdata(r_mem_rd),
    .sel(r_sel), .wr_en(r_wr), .rd_en(r_rd), .q(r_q), .q_en(r_q_en)
  );

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(srst_n),
    .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_mem_rd),
    .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_mem_rd)
  );

  assign l_busy_n = !l_block;
  assign r_busy_n = !r_block;

  AST_LEFT_BUSY_ON_MATCH: assert property (@(posedge clk) disable iff (!srst_n)
    !l_busy_n |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr))); // R5
  AST_RIGHT_BUSY_ON_MATCH: assert property (@(posedge clk) disable iff (!srst_n)
    !r_busy_n |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr))); // R5
  AST_LEFT_STANDBY_FREE: assert property (@(posedge clk) disable iff (!srst_n)
    l_cs_n |-> l_busy_n); // R2
  AST_RIGHT_STANDBY_FREE: assert property (@(posedge clk) disable iff (!srst_n)
    r_cs_n |-> r_busy_n); // R2
  AST_BLOCKED_READ_SILENT: assert property (@(posedge clk) disable iff (!srst_n)
    (!l_busy_n && l_we_n) |=> !l_rd || l_busy_n); // R8
endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          lcs, lwe, loe, rcs, rwe, roe;
  logic [AW-1:0] la, ra;
  logic [DW-1:0] ld, rd;
  logic [DW-1:0] l_q, r_q;
  logic          l_q_en, r_q_en, l_busy_n, r_busy_n;

  dpram_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(lcs), .l_we_n(lwe), .l_oe_n(loe), .l_addr(la), .l_wdata(ld),
    .l_q(l_q), .l_q_en(l_q_en), .l_busy_n(l_busy_n),
    .r_cs_n(rcs), .r_we_n(rwe), .r_oe_n(roe), .r_addr(ra), .r_wdata(rd),
    .r_q(r_q), .r_q_en(r_q_en), .r_busy_n(r_busy_n)
  );

  // signal codes for the scoreboard
  localparam int S_LBUSY = 0, S_RBUSY = 1, S_LQ = 2, S_LQEN = 3, S_RQ = 4, S_RQEN = 5;

  typedef struct {
    int          sig;
    logic [7:0]  exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  item_t cur;
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [7:0] observe(int sig);
    case (sig)
      S_LBUSY: return {7'b0, l_busy_n};
      S_RBUSY: return {7'b0, r_busy_n};
      S_LQ:    return l_q;
      S_LQEN:  return {7'b0, l_q_en};
      S_RQ:    return r_q;
      default: return {7'b0, r_q_en};
    endcase
  endfunction

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      total++;
      if (observe(cur.sig) !== cur.exp) begin
        bad++;
        $display("FAIL %s sig=%0d actual=%h expected=%h t=%0t",
                 cur.req, cur.sig, observe(cur.sig), cur.exp, $time);
      end
    end
  end

  task automatic expect_val(int sig, logic [7:0] v, string req);
    item_t it;
    it.sig = sig; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    lcs = 1; lwe = 1; loe = 1;
    rcs = 1; rwe = 1; roe = 1;
  endtask

  task automatic wr_left(logic [AW-1:0] a, logic [DW-1:0] d);
    step(); idle(); lcs = 0; lwe = 0; la = a; ld = d;
  endtask

  initial begin
    rst_n = 0; idle(); la = '0; ra = '0; ld = '0; rd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) step();
    step();
    expect_val(S_LBUSY, 8'd1, "R11"); expect_val(S_RBUSY, 8'd1, "R11");
    expect_val(S_LQEN, 8'd0, "R11");  expect_val(S_RQEN, 8'd0, "R11");

    // parallel writes then crossed reads on different words
    step(); idle(); lcs = 0; lwe = 0; la = 11'h010; ld = 8'hA5;
                    rcs = 0; rwe = 0; ra = 11'h020; rd = 8'h3C;
    expect_val(S_LBUSY, 8'd1, "R3"); expect_val(S_RBUSY, 8'd1, "R3");
    step(); idle(); lcs = 0; la = 11'h020; loe = 0; rcs = 0; ra = 11'h010; roe = 0;
    expect_val(S_LBUSY, 8'd1, "R5"); expect_val(S_RBUSY, 8'd1, "R5");
    step(); idle(); loe = 0; roe = 0;
    expect_val(S_LQ, 8'h3C, "R3"); expect_val(S_LQEN, 8'd1, "R3");
    expect_val(S_RQ, 8'hA5, "R3"); expect_val(S_RQEN, 8'd1, "R3");

    // boundary addresses
    step(); idle(); lcs = 0; lwe = 0; la = 11'h7FF; ld = 8'h81;
                    rcs = 0; rwe = 0; ra = 11'h000; rd = 8'h7E;
    step(); idle(); lcs = 0; la = 11'h000; loe = 0; rcs = 0; ra = 11'h7FF; roe = 0;
    step(); idle(); loe = 0; roe = 0;
    expect_val(S_LQ, 8'h7E, "R1"); expect_val(S_RQ, 8'h81, "R1");

    // output enable
    step(); idle(); lcs = 0; la = 11'h010;
    step(); idle(); lcs = 0; la = 11'h010;
    expect_val(S_LQEN, 8'd0, "R4"); expect_val(S_LQ, 8'h00, "R4");
    step(); idle(); lcs = 0; la = 11'h010; loe = 0;
    expect_val(S_LQEN, 8'd1, "R4"); expect_val(S_LQ, 8'hA5, "R4");

    // standby: write strobe with select high does nothing
    step(); idle(); lwe = 0; la = 11'h010; ld = 8'hFF;
    expect_val(S_LBUSY, 8'd1, "R2");
    step(); idle(); lcs = 0; la = 11'h010; loe = 0;
    step(); idle(); loe = 0;
    expect_val(S_LQ, 8'hA5, "R2");
    step(); idle(); la = 11'h010; rcs = 0; ra = 11'h010;
    expect_val(S_LBUSY, 8'd1, "R2"); expect_val(S_RBUSY, 8'd1, "R2");

    wr_left(11'h055, 8'h11);
    wr_left(11'h066, 8'h22);
    wr_left(11'h070, 8'h5A);

    // select order: left selected first
    step(); idle(); lcs = 0; la = 11'h055; ra = 11'h055;
    expect_val(S_RBUSY, 8'd1, "R6");
    step(); idle(); lcs = 0; la = 11'h055; rcs = 0; rwe = 0; ra = 11'h055; rd = 8'h99;
    expect_val(S_RBUSY, 8'd0, "R6"); expect_val(S_LBUSY, 8'd1, "R6");
    step();
    expect_val(S_RBUSY, 8'd0, "R10"); expect_val(S_LBUSY, 8'd1, "R10");
    step(); lcs = 1;
    expect_val(S_RBUSY, 8'd1, "R9");
    step(); idle(); lcs = 0; la = 11'h055; loe = 0;
    step(); idle(); loe = 0;
    expect_val(S_LQ, 8'h99, "R9");

    // same-cycle selects: left wins; blocked right read yields nothing
    step(); idle(); lcs = 0; lwe = 0; la = 11'h066; ld = 8'h44; rcs = 0; ra = 11'h066; roe = 0;
    expect_val(S_RBUSY, 8'd0, "R6"); expect_val(S_LBUSY, 8'd1, "R6");
    step();
    expect_val(S_RQEN, 8'd0, "R8");
    step(); idle(); rcs = 0; ra = 11'h066; roe = 0;
    expect_val(S_RBUSY, 8'd1, "R9"); expect_val(S_RQEN, 8'd0, "R8");
    step(); idle(); roe = 0;
    expect_val(S_RQ, 8'h44, "R9"); expect_val(S_RQEN, 8'd1, "R9");

    // select order: right first; blocked left write abandoned
    step(); idle(); rcs = 0; ra = 11'h070; la = 11'h070;
    expect_val(S_LBUSY, 8'd1, "R6");
    step(); idle(); rcs = 0; ra = 11'h070; lcs = 0; lwe = 0; la = 11'h070; ld = 8'hEE;
    expect_val(S_LBUSY, 8'd0, "R6"); expect_val(S_RBUSY, 8'd1, "R6");
    step(); idle(); rcs = 0; ra = 11'h070;
    expect_val(S_LBUSY, 8'd1, "R8");
    step(); idle(); lcs = 0; la = 11'h070; loe = 0;
    step(); idle(); loe = 0;
    expect_val(S_LQ, 8'h5A, "R8");

    // address order
    step(); idle(); lcs = 0; la = 11'h030; rcs = 0; ra = 11'h031;
    expect_val(S_LBUSY, 8'd1, "R7"); expect_val(S_RBUSY, 8'd1, "R7");
    step(); ra = 11'h030;
    expect_val(S_RBUSY, 8'd0, "R7"); expect_val(S_LBUSY, 8'd1, "R7");
    step(); la = 11'h033;
    expect_val(S_RBUSY, 8'd1, "R9");
    step(); la = 11'h040; ra = 11'h041;
    step(); la = 11'h041;
    expect_val(S_LBUSY, 8'd0, "R7"); expect_val(S_RBUSY, 8'd1, "R7");
    step(); la = 11'h050; ra = 11'h051;
    expect_val(S_LBUSY, 8'd1, "R7"); expect_val(S_RBUSY, 8'd1, "R7");
    step(); la = 11'h052; ra = 11'h052;
    expect_val(S_RBUSY, 8'd0, "R7"); expect_val(S_LBUSY, 8'd1, "R7");

    step(); idle();
    @(negedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule